// File: doc/BRIEF.md
# Dual Parallel Port Adapter with Input Handshake

This block hangs off a simple processor bus and presents two independent 8-bit parallel ports, called A and B. Each port has three registers behind it: an output data register, a per-bit direction register and a small control register. The processor reaches them through a chip select, separate read and write enables, and a two-bit register select. Each pin can be an input or an output on its own.

On the input side each port runs a strobe handshake with an external device. A rising edge on the port's strobe pin freezes the pin values in an input holding register. It also raises the port's acknowledge line and, if enabled, pulls the port's active-low interrupt request low. The handshake closes when the processor reads that port's data register: the read returns the held byte and, on the same clock edge, drops the acknowledge and releases the interrupt. No separate clear write is needed. The strobe is an asynchronous pin and is synchronised before its edge is detected. Each port has its own interrupt line, so software can service the two ports independently.

Top module: `pport_dual`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared. All pins become inputs (`*_oe` = 0), `*_out` = 0, both acknowledges are 0, both interrupt lines are 1, and every control register reads 0x00.
- R2: The register select `rs[1]` picks the port (0 = A, 1 = B). With `rs[0]` = 1 the control register is accessed. With `rs[0]` = 0 the data register is accessed when control bit 2 is 1, and the direction register when that bit is 0.
- R3: Direction register bit n set to 1 makes pin n an output (`*_oe[n]` = 1); 0 makes it an input. The register holds its value until it is written.
- R4: `*_out` always shows the port's output data register.
- R5: A data register read returns the output data register on output bits and the input holding register on input bits.
- R6: While no strobe is pending, the input holding register follows the pins. On a detected strobe rising edge it captures the pins and then holds, whatever the pins do, until the pending strobe is cleared.
- R7: A strobe rising edge sets the port's pending flag. This drives its acknowledge to 1, and its interrupt line to 0 when control bit 0 (interrupt enable) is 1.
- R8: A processor read of the data register clears the pending flag, so acknowledge is 0 and the interrupt line is 1 after that edge. Reads of the control register or the direction register leave the flag unchanged.
- R9: With control bit 0 = 0, a strobe still sets the flag and the acknowledge, but the interrupt line stays 1. The control register reads the flag in bit 7, data-select in bit 2 and interrupt enable in bit 0, with all other bits 0.
- R10: Ports A and B are independent. A strobe, a write or a read on one port changes nothing on the other port's outputs.
- R11: Writes and reads with `cs` low have no effect, and `rdata` is 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Chip select |
| wr_en | input | 1 | Write enable (with cs) |
| rd_en | input | 1 | Read enable (with cs) |
| rs | input | 2 | Register select: [1] port, [0] control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is selected |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output data register |
| pa_oe | output | 8 | Port A per-bit output enable |
| pa_stb | input | 1 | Port A input strobe (asynchronous) |
| pa_ack | output | 1 | Port A acknowledge |
| pa_irq_n | output | 1 | Port A interrupt request, active low |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output data register |
| pb_oe | output | 8 | Port B per-bit output enable |
| pb_stb | input | 1 | Port B input strobe (asynchronous) |
| pb_ack | output | 1 | Port B acknowledge |
| pb_irq_n | output | 1 | Port B interrupt request, active low |

## Verification
The assertions check on every cycle that:
- a detected strobe edge sets the pending flag and the acknowledge on the next edge;
- a data register read with no coincident strobe drops the acknowledge;
- the holding register stays frozen while a strobe is pending;
- the direction outputs change only on a direction register write.

Only the bench scenarios can show the rest:
- the address decode through the data-select bit;
- the mix of latched input bits and driven output bits in a read;
- the interrupt masking;
- that non-data reads do not close the handshake;
- that the two ports do not disturb each other.

// File: rtl/pport_pkg.sv
// Shared definitions for the dual parallel port adapter.
// Assumes data width of at least 8 so the control bit positions fit.
package pport_pkg;

    // Control register bit positions
    localparam int CTL_IRQ_EN = 0;
    localparam int CTL_DSEL   = 2;
    localparam int CTL_FLAG   = 7;

    typedef enum logic [1:0] {
        ACC_DIR  = 2'd0,
        ACC_DATA = 2'd1,
        ACC_CTRL = 2'd2
    } access_e;

    // Which register a port-local select bit reaches, given data-select.
    function automatic access_e decode_access(input logic ctl_sel, input logic dsel);
        if (ctl_sel)
            return ACC_CTRL;
        else if (dsel)
            return ACC_DATA;
        else
            return ACC_DIR;
    endfunction

endpackage

// File: rtl/pport_strobe_sync.sv
// Synchronises an asynchronous strobe pin and flags its rising edge for
// one clock. Assumes STAGES >= 2 and strobe pulses longer than STAGES+1 clocks.
module pport_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_async,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw strobe through the synchroniser and keep the last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], stb_async};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pport_channel.sv
// One port: output data, direction and control registers, input holding
// register and strobe handshake. Assumes sel is already qualified by chip
// select and port address; rdata is zero unless a read hits this port.
module pport_channel
    import pport_pkg::*;
#(
    parameter int DW     = 8,
    parameter int SYNC_N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          ctl_sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_oe,
    input  logic          stb,
    output logic          ack,
    output logic          irq_n
);
    logic [DW-1:0] ddr_q, odr_q, latch_q, ctl_rd;
    logic          irq_en_q, dsel_q, flag_q;
    logic          stb_rise, wr_hit, rd_hit, data_rd;
    access_e       acc;

    pport_strobe_sync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_async (stb),
        .rise      (stb_rise)
    );

    assign acc     = decode_access(ctl_sel, dsel_q);
    assign wr_hit  = sel & wr_en;
    assign rd_hit  = sel & rd_en;
    assign data_rd = rd_hit && (acc == ACC_DATA);

    // Register writes from the processor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ddr_q    <= '0;
            odr_q    <= '0;
            irq_en_q <= 1'b0;
            dsel_q   <= 1'b0;
        end else if (wr_hit) begin
            unique case (acc)
                ACC_DIR:  ddr_q <= wdata;
                ACC_DATA: odr_q <= wdata;
                default: begin
                    irq_en_q <= wdata[CTL_IRQ_EN];
                    dsel_q   <= wdata[CTL_DSEL];
                end
            endcase
        end
    end

    // Pending flag: a strobe sets it, a data read clears it, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (stb_rise)
            flag_q <= 1'b1;
        else if (data_rd)
            flag_q <= 1'b0;
    end

    // Holding register: follows pins when idle, captures on strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (stb_rise || !flag_q)
            latch_q <= pin_in;
    end

    // Control register read image
    always_comb begin
        ctl_rd             = '0;
        ctl_rd[CTL_IRQ_EN] = irq_en_q;
        ctl_rd[CTL_DSEL]   = dsel_q;
        ctl_rd[CTL_FLAG]   = flag_q;
    end

    // Read multiplexer, gated by the read strobe
    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            unique case (acc)
                ACC_DIR:  rdata = ddr_q;
                ACC_DATA: rdata = (odr_q & ddr_q) | (latch_q & ~ddr_q);
                default:  rdata = ctl_rd;
            endcase
        end
    end

    assign pin_out = odr_q;
    assign pin_oe  = ddr_q;
    assign ack     = flag_q;
    assign irq_n   = ~(flag_q & irq_en_q);

    a_r7_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise |=> ack);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !stb_rise) |=> (!ack && irq_n));

    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !stb_rise) |=> $stable(latch_q));

    a_r3_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && acc == ACC_DIR) |=> $stable(pin_oe));

endmodule

// File: rtl/pport_dual.sv
// Two-port parallel adapter. Decodes chip select and register select to
// the port channels and merges their read data. Assumes single-cycle
// bus accesses with rd_en and wr_en not both high.
module pport_dual #(
    parameter int DW     = 8,
    parameter int SYNC_N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    rs,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic          pa_stb,
    output logic          pa_ack,
    output logic          pa_irq_n,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic          pb_stb,
    output logic          pb_ack,
    output logic          pb_irq_n
);
    localparam int NPORT = 2;

    logic [DW-1:0] pin_in_v [NPORT];
    logic [DW-1:0] pin_out_v[NPORT];
    logic [DW-1:0] pin_oe_v [NPORT];
    logic [DW-1:0] rd_v     [NPORT];
    logic          stb_v    [NPORT];
    logic          ack_v    [NPORT];
    logic          irq_v    [NPORT];

    assign pin_in_v[0] = pa_in;
    assign pin_in_v[1] = pb_in;
    assign stb_v[0]    = pa_stb;
    assign stb_v[1]    = pb_stb;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        pport_channel #(.DW(DW), .SYNC_N(SYNC_N)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (cs && (rs[1] == 1'(g))),
            .wr_en   (wr_en),
            .rd_en   (rd_en),
            .ctl_sel (rs[0]),
            .wdata   (wdata),
            .rdata   (rd_v[g]),
            .pin_in  (pin_in_v[g]),
            .pin_out (pin_out_v[g]),
            .pin_oe  (pin_oe_v[g]),
            .stb     (stb_v[g]),
            .ack     (ack_v[g]),
            .irq_n   (irq_v[g])
        );
    end

    // Only the selected channel drives nonzero read data
    assign rdata    = rd_v[0] | rd_v[1];
    assign pa_out   = pin_out_v[0];
    assign pa_oe    = pin_oe_v[0];
    assign pa_ack   = ack_v[0];
    assign pa_irq_n = irq_v[0];
    assign pb_out   = pin_out_v[1];
    assign pb_oe    = pin_oe_v[1];
    assign pb_ack   = ack_v[1];
    assign pb_irq_n = irq_v[1];

    a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd_en) |-> (rdata == '0));

endmodule

// File: tb/pport_dual_tb_top.sv
// Directed bench for the dual parallel port adapter.
module pport_dual_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] rs = 2'd0;
    logic [7:0] wdata = 8'h00, rdata;
    logic [7:0] pa_in = 8'h00, pa_out, pa_oe;
    logic [7:0] pb_in = 8'h00, pb_out, pb_oe;
    logic       pa_stb = 1'b0, pb_stb = 1'b0;
    logic       pa_ack, pa_irq_n, pb_ack, pb_irq_n;
    int         checks = 0, errors = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    pport_dual dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
        .rs(rs), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_stb(pa_stb),
        .pa_ack(pa_ack), .pa_irq_n(pa_irq_n),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_stb(pb_stb),
        .pb_ack(pb_ack), .pb_irq_n(pb_irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        cs = sel; wr_en = 1'b1; rs = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd_en = 1'b1; rs = a;
        #2 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd_en = 1'b0;
    endtask

    task automatic pulse(input logic port_b);
        @(negedge clk);
        if (port_b) pb_stb = 1'b1; else pa_stb = 1'b1;
        repeat (5) @(negedge clk);
        pa_stb = 1'b0; pb_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pa_out", pa_out, 8'h00);
        check("R1 ack/irq", {6'd0, pa_ack, pa_irq_n}, 8'h01);
        check("R1 pb ack/irq", {6'd0, pb_ack, pb_irq_n}, 8'h01);
        rd(2'd1, rv); check("R1 ctrl A", rv, 8'h00);
        check("R11 idle rdata", rdata, 8'h00);
    endtask

    task automatic t_regs;
        wr(2'd0, 8'hF0);                      // direction A (data-select 0)
        check("R3 pa_oe", pa_oe, 8'hF0);
        check("R10 pb_oe", pb_oe, 8'h00);
        rd(2'd0, rv); check("R2 dir readback", rv, 8'hF0);
        wr(2'd1, 8'h05);                      // irq enable + data-select
        rd(2'd1, rv); check("R9 ctrl image", rv, 8'h05);
        wr(2'd0, 8'hA5);
        check("R4 pa_out", pa_out, 8'hA5);
        check("R3 pa_oe kept", pa_oe, 8'hF0);
        pa_in = 8'h3C; repeat (2) @(negedge clk);
        rd(2'd0, rv); check("R5 mixed read", rv, 8'hAC);
        wr(2'd0, 8'h11, 1'b0);
        check("R11 cs low write", pa_out, 8'hA5);
    endtask

    task automatic t_handshake;
        pa_in = 8'h5A;
        pulse(1'b0);
        check("R7 ack/irq after strobe", {6'd0, pa_ack, pa_irq_n}, 8'h02);
        pa_in = 8'hFF; repeat (2) @(negedge clk);
        rd(2'd1, rv); check("R9 flag in ctrl", rv, 8'h85);
        check("R8 ctrl read keeps ack", {7'd0, pa_ack}, 8'h01);
        rd(2'd0, rv); check("R6 held byte", rv, 8'hAA);
        check("R8 ack/irq after data read", {6'd0, pa_ack, pa_irq_n}, 8'h01);
    endtask

    task automatic t_mask;
        wr(2'd1, 8'h04);
        pa_in = 8'h00; pulse(1'b0);
        check("R9 masked irq", {6'd0, pa_ack, pa_irq_n}, 8'h03);
        rd(2'd0, rv); check("R9 masked read", rv, 8'hA0);
        check("R8 masked clear", {7'd0, pa_ack}, 8'h00);
    endtask

    task automatic t_port_b;
        wr(2'd3, 8'h05);
        pb_in = 8'h33; pulse(1'b1);
        check("R10 pb ack/irq", {6'd0, pb_ack, pb_irq_n}, 8'h02);
        check("R10 pa untouched", {6'd0, pa_ack, pa_irq_n}, 8'h01);
        rd(2'd2, rv); check("R10 pb data", rv, 8'h33);
        check("R8 pb cleared", {6'd0, pb_ack, pb_irq_n}, 8'h01);
        check("R10 pa_out kept", pa_out, 8'hA5);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_handshake();
        t_mask();
        t_port_b();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule